// File: doc/BRIEF.md
# Gated-Period Tone Frequency Counter

This block measures the frequency of a squared, already synchronised tone. It counts rising edges of the tone over a gate of fixed length, and the length of that gate depends on the band the band selector has chosen. At the end of every gate that runs without a break, it publishes a 6-bit word and a one-cycle load strobe for the serial output port. Bit 5 of the word is the band flag and bits 4..0 hold the edge count N. N is the integer part of tone frequency times gate time. For example, in the high band an N of 22 means a tone near 1680 to 1740 Hz.

Four conditions throw away the gate in progress: a band-change pulse, the level-enable going inactive, a bad signal-quality indication, and a frequency-out-of-range flag. The gate timer and the edge counter both return to zero, and no word is produced for that gate. Counting starts again from zero on the first clock after the condition clears. With no such condition, gates follow each other without a gap, so a steady tone gives one result per gate period.

The control is a three-state machine:
- **HOLD** is the state after reset or after any abort. No counting happens here.
- **GATE** is the state in which the gate runs.
- **DONE** is the one cycle that carries the load strobe. It is also the first cycle of the next gate.

The transitions are:
- HOLD→GATE on the first clean clock.
- GATE→GATE while the gate is not yet full.
- GATE→DONE on the final gate cycle.
- DONE→GATE while the next gate continues.
- Any state→HOLD on an abort.

Top module: `tone_gate_counter`

## Requirements
- R1: A gate lasts LO_GATE_CLKS clocks when band_hi is 0 and HI_GATE_CLKS clocks when band_hi is 1 (defaults 141285 and 47107). After a clean start (abort inputs sampled inactive at clock edge E0), load_o is high only after clock edge E0 + gate length.
- R2: word_o[4:0] equals the number of rising edges of tone_sq sampled at the clock edges E1 through E_gate of the gate that just finished.
- R3: word_o[5] equals band_hi during the final gate cycle: 1 for the high band, 0 for the low band.
- R4: The edge count saturates at 31 and does not wrap, so a gate with more than 31 rising edges reports 31.
- R5: load_o is high for exactly one cycle per completed gate. Gates run back to back, so with no abort the next strobe comes exactly one gate length later.
- R6: A high pulse on band_chg aborts the gate: no strobe for it, and a full new gate starts after the pulse.
- R7: level_en low aborts the gate in the same way.
- R8: quality_ok low aborts the gate in the same way.
- R9: freq_oor high aborts the gate in the same way.
- R10: An abort sampled on the final cycle of a gate suppresses that gate's strobe.
- R11: word_o holds its value between strobes. After reset, word_o is 0 and load_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tone_sq | input | 1 | Synchronised squared tone |
| band_hi | input | 1 | Selected band, 1 = high |
| band_chg | input | 1 | One-cycle pulse when the band selection changes |
| level_en | input | 1 | Level enable, 0 aborts counting |
| quality_ok | input | 1 | Signal quality good, 0 aborts counting |
| freq_oor | input | 1 | Frequency out of range, 1 aborts counting |
| word_o | output | 6 | Result word {band, N} |
| load_o | output | 1 | One-cycle load strobe for the serial port |

## Verification
The timer, the counter and the state machine are each visible at the ports within one gate:
- A timer that is off by one moves the load strobe by a cycle, against a bench that expects it on an exact tick after a clean start.
- A counter that wraps or mis-clears shows up as a wrong N on the very next strobe, because the bench keeps its own record of the edges it drove in that window.
- A state machine that fails to reach HOLD on an abort lets a stale strobe through within the same gate length.

// File: rtl/tgc_pkg.sv
package tgc_pkg;

    // Control states of the gated counter
    typedef enum logic [1:0] {
        ST_HOLD = 2'd0,   // idle after reset or abort, nothing counts
        ST_GATE = 2'd1,   // gate running
        ST_DONE = 2'd2    // strobe cycle, also first cycle of next gate
    } tgc_state_e;

endpackage

// File: rtl/tgc_rise_det.sv
module tgc_rise_det (
    input  logic clk,
    input  logic rst_n,
    input  logic sig_i,
    output logic rise_o
);

    logic sig_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sig_q <= 1'b0;
        end else begin
            sig_q <= sig_i;
        end
    end

    assign rise_o = sig_i & ~sig_q;

endmodule

// File: rtl/tgc_gate_timer.sv
module tgc_gate_timer #(
    parameter int LO_LEN = 141285,
    parameter int HI_LEN = 47107
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    input  logic run_i,
    input  logic band_hi_i,
    output logic last_o
);

    localparam int MAX_LEN = (LO_LEN > HI_LEN) ? LO_LEN : HI_LEN;
    localparam int TW      = $clog2(MAX_LEN + 1);

    logic [TW-1:0] tmr_q;
    logic [TW-1:0] end_val;

    // Terminal value is picked by the current band
    assign end_val = band_hi_i ? TW'(HI_LEN - 1) : TW'(LO_LEN - 1);
    assign last_o  = (tmr_q >= end_val);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tmr_q <= '0;
        end else if (clr_i) begin
            tmr_q <= '0;
        end else if (run_i) begin
            tmr_q <= tmr_q + TW'(1);
        end
    end

    // R1
    tmr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_q <= TW'(MAX_LEN - 1));

    // R1
    tmr_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (tmr_q == '0));

endmodule

// File: rtl/tgc_edge_counter.sv
module tgc_edge_counter #(
    parameter int W        = 5,
    parameter bit SATURATE = 1'b1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr_i,
    input  logic         inc_i,
    output logic [W-1:0] cnt_o,
    output logic [W-1:0] nxt_o
);

    localparam logic [W-1:0] TOP = {W{1'b1}};

    logic [W-1:0] cnt_q;
    logic [W-1:0] bumped;

    generate
        if (SATURATE) begin : g_sat
            always_comb begin
                bumped = (cnt_q == TOP) ? cnt_q : cnt_q + W'(1);
            end
        end else begin : g_wrap
            always_comb begin
                bumped = cnt_q + W'(1);
            end
        end
    endgenerate

    assign nxt_o = inc_i ? bumped : cnt_q;
    assign cnt_o = cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr_i) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= nxt_o;
        end
    end

    generate
        if (SATURATE) begin : g_sat_chk
            // R4
            cnt_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (cnt_q == TOP && !clr_i) |=> (cnt_q == TOP));
        end
    endgenerate

endmodule

// File: rtl/tone_gate_counter.sv
module tone_gate_counter #(
    parameter int LO_GATE_CLKS = 141285,
    parameter int HI_GATE_CLKS = 47107,
    parameter int CNT_W        = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tone_sq,
    input  logic             band_hi,
    input  logic             band_chg,
    input  logic             level_en,
    input  logic             quality_ok,
    input  logic             freq_oor,
    output logic [CNT_W:0]   word_o,
    output logic             load_o
);

    import tgc_pkg::*;

    localparam int WORD_W = CNT_W + 1;

    tgc_state_e state_q;
    tgc_state_e state_d;

    logic             abort;
    logic             running;
    logic             gate_last;
    logic             gate_end;
    logic             clr;
    logic             rise;
    logic [CNT_W-1:0] cnt_cur;
    logic [CNT_W-1:0] cnt_nxt;
    logic [WORD_W-1:0] word_q;
    logic             load_q;

    // Any qualifying condition throws away the gate in progress
    assign abort    = band_chg | ~level_en | ~quality_ok | freq_oor;
    assign running  = (state_q != ST_HOLD) && !abort;
    assign gate_end = running && gate_last;
    assign clr      = abort || (state_q == ST_HOLD) || gate_end;

    tgc_rise_det u_rise (
        .clk    (clk),
        .rst_n  (rst_n),
        .sig_i  (tone_sq),
        .rise_o (rise)
    );

    tgc_gate_timer #(
        .LO_LEN (LO_GATE_CLKS),
        .HI_LEN (HI_GATE_CLKS)
    ) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr_i     (clr),
        .run_i     (running),
        .band_hi_i (band_hi),
        .last_o    (gate_last)
    );

    tgc_edge_counter #(
        .W        (CNT_W),
        .SATURATE (1'b1)
    ) u_count (
        .clk   (clk),
        .rst_n (rst_n),
        .clr_i (clr),
        .inc_i (running & rise),
        .cnt_o (cnt_cur),
        .nxt_o (cnt_nxt)
    );

    // Next-state logic
    always_comb begin
        state_d = state_q;
        if (abort) begin
            state_d = ST_HOLD;
        end else begin
            unique case (state_q)
                ST_HOLD: state_d = ST_GATE;
                ST_GATE: state_d = gate_last ? ST_DONE : ST_GATE;
                ST_DONE: state_d = gate_last ? ST_DONE : ST_GATE;
                default: state_d = ST_HOLD;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_HOLD;
        end else begin
            state_q <= state_d;
        end
    end

    // Output register: word captured and strobe raised at the end of a clean gate
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            word_q <= '0;
            load_q <= 1'b0;
        end else begin
            load_q <= gate_end;
            if (gate_end) begin
                word_q <= {band_hi, cnt_nxt};
            end
        end
    end

    assign word_o = word_q;
    assign load_o = load_q;

    // R5
    load_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_o |=> !load_o);

    // R6 R7 R8 R9 R10
    abort_noload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        abort |=> !load_o);

    // R3
    band_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_o |-> (word_o[CNT_W] == $past(band_hi)));

    // R11
    word_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !load_o |-> $stable(word_o));

    // R1
    hold_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HOLD) |=> (cnt_cur == '0));

endmodule

// File: tb/tone_gate_counter_tb.sv
module tone_gate_counter_tb_top;

    localparam int G_LO = 72;
    localparam int G_HI = 24;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tone_sq = 1'b0;
    logic       band_hi = 1'b0;
    logic       band_chg = 1'b0;
    logic       level_en = 1'b1;
    logic       quality_ok = 1'b1;
    logic       freq_oor = 1'b0;
    logic [5:0] word_o;
    logic       load_o;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    logic [127:0] hist = '0;
    logic         last_rise = 1'b0;
    int           period = 0;
    int           ph = 0;

    // bit 7 = band (1 high), bits 6..0 = tone period in clocks (0 = held low)
    localparam logic [7:0] VEC [8] = '{8'h06, 8'h02, 8'h83, 8'h82,
                                       8'h04, 8'h99, 8'h80, 8'h01};

    always #4 clk = ~clk;

    tone_gate_counter #(
        .LO_GATE_CLKS (G_LO),
        .HI_GATE_CLKS (G_HI),
        .CNT_W        (5)
    ) dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .tone_sq    (tone_sq),
        .band_hi    (band_hi),
        .band_chg   (band_chg),
        .level_en   (level_en),
        .quality_ok (quality_ok),
        .freq_oor   (freq_oor),
        .word_o     (word_o),
        .load_o     (load_o)
    );

    function automatic int cur_g();
        return band_hi ? G_HI : G_LO;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // One clock: sample outputs, check any strobe's word, then drive the next tone level
    task automatic tick();
        int g;
        int e;
        logic old;
        logic [127:0] mask;
        @(negedge clk);
        hist = {hist[126:0], last_rise};
        if (load_o) begin
            g = cur_g();
            mask = (128'd1 << g) - 128'd1;
            e = $countones(hist & mask);
            if (e > 31) e = 31;
            chk(word_o == {band_hi, e[4:0]}, "R2 R3 R4 result word",
                int'(word_o), int'({band_hi, e[4:0]}));
        end
        old = tone_sq;
        if (period == 0) begin
            tone_sq = 1'b0;
        end else begin
            ph = (ph + 1) % period;
            tone_sq = (ph >= period / 2);
        end
        last_rise = tone_sq & ~old;
    endtask

    // After a release: no strobe for g ticks, strobe on the next
    task automatic run_clean(input string tag);
        int g;
        g = cur_g();
        for (int i = 1; i <= g; i++) begin
            tick();
            chk(!load_o, tag, int'(load_o), 0);
        end
        tick();
        chk(load_o, tag, int'(load_o), 1);
    endtask

    task automatic follow_gate(input string tag);
        int g;
        g = cur_g();
        for (int i = 1; i < g; i++) begin
            tick();
            chk(!load_o, tag, int'(load_o), 0);
        end
        tick();
        chk(load_o, tag, int'(load_o), 1);
    endtask

    // Assert one abort source for one clock, then release
    task automatic abort_with(input int sel);
        case (sel)
            0: begin band_hi = ~band_hi; band_chg = 1'b1; end
            1: level_en = 1'b0;
            2: quality_ok = 1'b0;
            default: freq_oor = 1'b1;
        endcase
        tick();
        band_chg = 1'b0;
        level_en = 1'b1;
        quality_ok = 1'b1;
        freq_oor = 1'b0;
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin
        repeat (4) tick();
        // R11 reset state
        chk(load_o == 1'b0, "R11 reset strobe", int'(load_o), 0);
        chk(word_o == 6'd0, "R11 reset word", int'(word_o), 0);
        rst_n = 1'b1;

        // Table walk: band, tone period; two back-to-back gates each
        for (int v = 0; v < 8; v++) begin
            band_hi  = VEC[v][7];
            period   = int'(VEC[v][6:0]);
            ph       = 0;
            band_chg = 1'b1;
            tick();
            band_chg = 1'b0;
            run_clean("R1 gate length");
            follow_gate("R5 back-to-back gate");
        end

        // Aborts mid-gate, one per source, high band, period 3
        period = 3;
        for (int s = 0; s < 4; s++) begin
            band_hi = 1'b1;
            abort_with(2);
            for (int i = 0; i < G_HI / 2; i++) begin
                tick();
                chk(!load_o, "R1 before abort", int'(load_o), 0);
            end
            abort_with(s);
            case (s)
                0: run_clean("R6 band change abort");
                1: run_clean("R7 level abort");
                2: run_clean("R8 quality abort");
                default: run_clean("R9 out-of-range abort");
            endcase
        end

        // Abort on the final cycle of a gate (low band)
        band_hi = 1'b0;
        abort_with(2);
        for (int i = 1; i <= G_LO; i++) begin
            tick();
            chk(!load_o, "R10 before last cycle", int'(load_o), 0);
        end
        abort_with(3);
        chk(!load_o, "R10 last-cycle abort", int'(load_o), 0);
        run_clean("R10 restart after last-cycle abort");

        // Word held between strobes
        begin
            logic [5:0] w;
            w = word_o;
            for (int i = 1; i < G_LO; i++) begin
                tick();
                chk(word_o == w, "R11 word hold", int'(word_o), int'(w));
            end
        end

        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        #1_600_000;
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            summary();
            $finish;
        end
    end

endmodule